// File: doc/BRIEF.md
# Dual-Port Semaphore Token Flags

This block holds a small bank of binary token flags that two independent ports share. It is kept apart from any data storage. A port that wants a shared resource picks a flag and writes a 0 to request it. It then reads the flag back: a 0 means the port now holds the token, and a 1 means the other side holds it. A port gives the token back by writing a 1. The flags drive no hardware themselves; software on each side decides what a token stands for.

Each port has its own enable, flag select, write strobe and one data bit. Reads are combinational from the current flag state, so neither port is ever stalled. When both ports ask for the same free flag, the conflict is settled deterministically. The port that loses stays queued and receives the token on the cycle after the owner releases it.

Top module: `dp_sem_flags`

## Requirements
- R1: After reset all eight flags are free with nothing queued, and a read of any flag returns 1 on both ports.
- R2: A port that writes 0 (wr=1, wdata=0) to a free flag becomes its owner from the next cycle. A read of that flag then returns 0 on the owning port and 1 on the other port.
- R3: A port whose enable is low changes no flag and no queued request, and its read data is 1. Read data is also 1 while the port is writing.
- R4: When both ports write 0 to the same free flag in the same cycle, the left port becomes owner and the right request is queued.
- R5: An owner that writes 1 frees the flag from the next cycle. A request queued by the other port is granted one cycle after that.
- R6: A write of 1 from a port that does not own the flag leaves the owner unchanged and cancels that port's queued request.
- R7: A write of 0 from the current owner leaves the flag owned by that port.
- R8: At no time do both ports read 0 from the same flag.
- R9: An operation on one flag never changes the state of any other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lsem_en | input | 1 | Left port semaphore enable |
| lsem_sel | input | SEL_W | Left port flag select |
| lsem_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| lsem_wdata | input | 1 | Left port write bit (0 = request, 1 = release) |
| lsem_rdata | output | 1 | Left port read bit (0 = token held by left) |
| rsem_en | input | 1 | Right port semaphore enable |
| rsem_sel | input | SEL_W | Right port flag select |
| rsem_wr | input | 1 | Right port write strobe |
| rsem_wdata | input | 1 | Right port write bit |
| rsem_rdata | output | 1 | Right port read bit (0 = token held by right) |

## Verification
The bench targets a same-cycle claim of one free flag by both ports. A design with the wrong tie-break would give the token to the right port, or to both ports. It checks that a queued request is handed over exactly one cycle after release. Granting it in the release cycle, or never, shows up as a wrong read value. It checks that a release written by the non-owner really cancels that port's queued request; a design that forgot the cancel would later hand out a token nobody is waiting for. A long random run confined to four flags compares both read ports on every cycle with a behavioural model, which catches state leaking between flags and disabled ports that still act.

// File: rtl/semflag_pkg.sv
package semflag_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
   parameter int SEL_W = 3,
   localparam int NUM_FLAGS = 1 << SEL_W
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   input  logic             wr,
   input  logic             wdata,
   output logic [NUM_FLAGS-1:0] claim,
   output logic [NUM_FLAGS-1:0] drop
);
   logic wr_act;
   assign wr_act = en & wr;

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_dec
      logic hit;
      assign hit      = (sel == SEL_W'(f));
      assign claim[f] = wr_act & hit & ~wdata;
      assign drop[f]  = wr_act & hit & wdata;
   end

   // R3: a disabled port issues no flag operation
   always_comb begin
      if (!en) begin
         idle_no_op_chk: assert ((claim | drop) == '0);
      end
   end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
   import semflag_pkg::*;
#(
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   l_claim,
   input  logic   l_drop,
   input  logic   r_claim,
   input  logic   r_drop,
   output owner_t own_q
);
   owner_t own_d;
   logic   pend_l_q, pend_r_q, pend_l_d, pend_r_d;
   logic   want_l, want_r, grab_l, grab_r;

   assign want_l = (pend_l_q | l_claim) & ~l_drop;
   assign want_r = (pend_r_q | r_claim) & ~r_drop;

   if (LEFT_WINS) begin : g_tie_left
      assign grab_l = want_l;
      assign grab_r = want_r & ~want_l;
   end else begin : g_tie_right
      assign grab_r = want_r;
      assign grab_l = want_l & ~want_r;
   end

   always_comb begin
      own_d    = own_q;
      pend_l_d = 1'b0;
      pend_r_d = 1'b0;
      unique case (own_q)
         OWN_NONE: begin
            if (grab_l) begin
               own_d    = OWN_LEFT;
               pend_r_d = want_r;
            end else if (grab_r) begin
               own_d    = OWN_RIGHT;
               pend_l_d = want_l;
            end
         end
         OWN_LEFT: begin
            if (l_drop) own_d = OWN_NONE;
            pend_r_d = want_r;
         end
         OWN_RIGHT: begin
            if (r_drop) own_d = OWN_NONE;
            pend_l_d = want_l;
         end
         default: own_d = OWN_NONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q    <= OWN_NONE;
         pend_l_q <= 1'b0;
         pend_r_q <= 1'b0;
      end else begin
         own_q    <= own_d;
         pend_l_q <= pend_l_d;
         pend_r_q <= pend_r_d;
      end
   end

   // R2
   claim_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && l_claim && !r_claim && !pend_r_q) |=> own_q == OWN_LEFT);
   // R2
   claim_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && r_claim && !l_claim && !pend_l_q) |=> own_q == OWN_RIGHT);
   if (LEFT_WINS) begin : g_tie_chk
      // R4
      tie_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (own_q == OWN_NONE && l_claim && r_claim) |=> (own_q == OWN_LEFT && pend_r_q));
   end
   // R5
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_LEFT && l_drop) |=> own_q == OWN_NONE);
   // R5
   handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && pend_r_q && !pend_l_q && !l_claim && !r_drop) |=> own_q == OWN_RIGHT);
   // R6
   cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_LEFT && r_drop) |=> !pend_r_q);
   // R7
   reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_RIGHT && r_claim && !r_drop) |=> own_q == OWN_RIGHT);
   // R9
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q != OWN_NONE && !l_claim && !l_drop && !r_claim && !r_drop) |=> $stable(own_q));
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux
   import semflag_pkg::*;
#(
   parameter int     SEL_W = 3,
   parameter owner_t ME    = OWN_LEFT,
   localparam int    NUM_FLAGS = 1 << SEL_W
) (
   input  logic             en,
   input  logic             wr,
   input  logic [SEL_W-1:0] sel,
   input  owner_t           owner_vec [NUM_FLAGS],
   output logic             rdata
);
   owner_t picked;
   assign picked = owner_vec[sel];
   assign rdata  = (en && !wr) ? (picked != ME) : 1'b1;
endmodule

// File: rtl/dp_sem_flags.sv
module dp_sem_flags
   import semflag_pkg::*;
#(
   parameter int SEL_W     = 3,
   parameter bit LEFT_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lsem_en,
   input  logic [SEL_W-1:0] lsem_sel,
   input  logic             lsem_wr,
   input  logic             lsem_wdata,
   output logic             lsem_rdata,
   input  logic             rsem_en,
   input  logic [SEL_W-1:0] rsem_sel,
   input  logic             rsem_wr,
   input  logic             rsem_wdata,
   output logic             rsem_rdata
);
   localparam int NUM_FLAGS = 1 << SEL_W;

   if (SEL_W < 1 || SEL_W > 6) begin : g_bad_sel
      $error("dp_sem_flags: SEL_W must be 1..6");
   end

   logic [NUM_FLAGS-1:0] l_claim, l_drop, r_claim, r_drop;
   owner_t               owner_vec [NUM_FLAGS];

   sem_port_decode #(.SEL_W(SEL_W)) u_ldec (
      .en(lsem_en), .sel(lsem_sel), .wr(lsem_wr), .wdata(lsem_wdata),
      .claim(l_claim), .drop(l_drop));
   sem_port_decode #(.SEL_W(SEL_W)) u_rdec (
      .en(rsem_en), .sel(rsem_sel), .wr(rsem_wr), .wdata(rsem_wdata),
      .claim(r_claim), .drop(r_drop));

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      sem_flag_cell #(.LEFT_WINS(LEFT_WINS)) u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_claim(l_claim[f]), .l_drop(l_drop[f]),
         .r_claim(r_claim[f]), .r_drop(r_drop[f]),
         .own_q(owner_vec[f]));
   end

   sem_read_mux #(.SEL_W(SEL_W), .ME(OWN_LEFT)) u_lrd (
      .en(lsem_en), .wr(lsem_wr), .sel(lsem_sel),
      .owner_vec(owner_vec), .rdata(lsem_rdata));
   sem_read_mux #(.SEL_W(SEL_W), .ME(OWN_RIGHT)) u_rrd (
      .en(rsem_en), .wr(rsem_wr), .sel(rsem_sel),
      .owner_vec(owner_vec), .rdata(rsem_rdata));

   // R8
   exclusive_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lsem_en && !lsem_wr && rsem_en && !rsem_wr && lsem_sel == rsem_sel)
         |-> (lsem_rdata || rsem_rdata));
endmodule

// File: tb/tb_dp_sem_flags.sv
`timescale 1ns/100ps
module tb_dp_sem_flags;
   logic clk = 1'b0, rst_n = 1'b0;
   logic l_en = 0, l_wr = 0, l_wd = 0, r_en = 0, r_wr = 0, r_wd = 0;
   logic [2:0] l_sel = 0, r_sel = 0;
   logic l_rd, r_rd;
   int checks = 0, failures = 0;
   int own [8];
   bit pl [8], pr [8];

   always #2.5 clk = ~clk;

   dp_sem_flags dut (
      .clk(clk), .rst_n(rst_n),
      .lsem_en(l_en), .lsem_sel(l_sel), .lsem_wr(l_wr), .lsem_wdata(l_wd), .lsem_rdata(l_rd),
      .rsem_en(r_en), .rsem_sel(r_sel), .rsem_wr(r_wr), .rsem_wdata(r_wd), .rsem_rdata(r_rd));

   function automatic logic exp_rd(bit en, bit wr, int sel, int me);
      if (en && !wr) return (own[sel] == me) ? 1'b0 : 1'b1;
      return 1'b1;
   endfunction

   task automatic model_step();
      for (int f = 0; f < 8; f++) begin
         bit lc = l_en && l_wr && !l_wd && l_sel == f;
         bit ld = l_en && l_wr && l_wd && l_sel == f;
         bit rc = r_en && r_wr && !r_wd && r_sel == f;
         bit rdp = r_en && r_wr && r_wd && r_sel == f;
         bit wl = (pl[f] || lc) && !ld;
         bit wrq = (pr[f] || rc) && !rdp;
         if (own[f] == 0) begin
            pl[f] = 0; pr[f] = 0;
            if (wl) begin own[f] = 1; pr[f] = wrq; end
            else if (wrq) own[f] = 2;
         end else if (own[f] == 1) begin
            if (ld) own[f] = 0;
            pl[f] = 0; pr[f] = wrq;
         end else begin
            if (rdp) own[f] = 0;
            pr[f] = 0; pl[f] = wl;
         end
      end
   endtask

   task automatic cyc(bit le, int ls, bit lw, bit ld, bit re, int rs, bit rw, bit rdv, string tag);
      @(negedge clk);
      l_en = le; l_sel = 3'(ls); l_wr = lw; l_wd = ld;
      r_en = re; r_sel = 3'(rs); r_wr = rw; r_wd = rdv;
      #1;
      checks++;
      if (l_rd !== exp_rd(le, lw, ls, 1)) begin
         failures++;
         $display("FAIL %s left rdata actual=%b expected=%b", tag, l_rd, exp_rd(le, lw, ls, 1));
      end
      checks++;
      if (r_rd !== exp_rd(re, rw, rs, 2)) begin
         failures++;
         $display("FAIL %s right rdata actual=%b expected=%b", tag, r_rd, exp_rd(re, rw, rs, 2));
      end
      @(posedge clk);
      model_step();
   endtask

   // read flag s on both ports
   task automatic rd_both(int s, string tag);
      cyc(1, s, 0, 0, 1, s, 0, 0, tag);
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int f = 0; f < 8; f++) begin own[f] = 0; pl[f] = 0; pr[f] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: all flags free after reset
      for (int f = 0; f < 8; f++) rd_both(f, "R1");
      // R2: left claims flag 3
      cyc(1, 3, 1, 0, 0, 0, 0, 0, "R2");
      rd_both(3, "R2");
      // R7: owner requests again
      cyc(1, 3, 1, 0, 0, 0, 0, 0, "R7");
      rd_both(3, "R7");
      // R3: disabled left write, reads while writing
      cyc(0, 5, 1, 0, 1, 5, 1, 1, "R3");
      rd_both(5, "R3");
      cyc(0, 3, 0, 0, 0, 3, 0, 0, "R3");
      // R4: simultaneous claim of flag 1
      cyc(1, 1, 1, 0, 1, 1, 1, 0, "R4");
      rd_both(1, "R4");
      // R5: left releases, right gets it one cycle later
      cyc(1, 1, 1, 1, 0, 0, 0, 0, "R5");
      rd_both(1, "R5");
      rd_both(1, "R5");
      // R6: right queues on flag 3, then cancels, then left releases
      cyc(0, 0, 0, 0, 1, 3, 1, 0, "R6");
      cyc(0, 0, 0, 0, 1, 3, 1, 1, "R6");
      rd_both(3, "R6");
      cyc(1, 3, 1, 1, 0, 0, 0, 0, "R6");
      rd_both(3, "R6");
      rd_both(3, "R6");
      // R9: other flags untouched
      for (int f = 0; f < 8; f++) rd_both(f, "R9");
      // R8/R9: random traffic on four flags
      for (int i = 0; i < 4000; i++) begin
         int op = $urandom_range(0, 9);
         cyc(bit'($urandom_range(0, 1)) | (op > 2), $urandom_range(0, 3), bit'($urandom_range(0, 1)),
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)) | (op > 4), $urandom_range(0, 3),
             bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), "R8");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule